// File: doc/BRIEF.md
# Lock-Qualified Errored Cell Accumulator

This block keeps a running tally of errored test cells reported by a test-cell receiver. The receiver presents a one-cycle pulse for each errored cell and a flag that is high while it is locked to the pseudo-random payload pattern. Pulses are counted only while that flag is high, because a count taken without lock carries no meaning. The tally is 16 bits wide and stops at its maximum instead of rolling over.

Software reads the tally through a byte-wide register port at two addresses, and every read clears what it returns. Reading the upper byte at 0Ch returns the upper half. In the same cycle it copies the lower half into a holding register and restarts the live tally from zero. A later read of the lower byte at 0Dh returns the held half, so both bytes describe the same instant. An errored cell that arrives in the same cycle as the clearing read is not lost: it becomes the first count of the new interval. Any other address reads as zero and changes nothing.

Top module: `tc_err_acc`

## Requirements
- R1: While the lock input is high, each cycle with the errored-cell input high adds one to the live tally, effective at the next clock edge.
- R2: After reset the live tally and the holding register are zero, the read data output is 00h and the lock indication is low.
- R3: The live tally stops at FFFFh; further qualified pulses leave it at FFFFh.
- R4: While the lock input is low, errored-cell pulses leave the live tally unchanged.
- R5: A read strobe with address 0Ch places bits 15:8 of the live tally on the read data output in the following cycle. The live tally becomes zero, or one if a qualified pulse arrives in the same cycle as the read.
- R6: A read of 0Ch copies bits 7:0 of the live tally into the holding register. The next read of 0Dh returns that copy, even if the live tally has advanced in between.
- R7: A read of 0Dh clears the holding register, so a second 0Dh read with no 0Ch read in between returns 00h.
- R8: A read strobe with any address other than 0Ch and 0Dh returns 00h. It changes neither the live tally nor the holding register.
- R9: The lock indication output equals the lock input delayed by one clock cycle.
- R10: The read data output keeps its last value on cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_cell | input | 1 | One pulse per errored test cell |
| pat_lock | input | 1 | High while the receiver holds pattern lock |
| rd_en | input | 1 | Register read strobe, one cycle per read |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 8 | Read data, valid the cycle after the strobe |
| lock_valid | output | 1 | Registered lock flag; the tally is meaningful while high |

## Verification
The bench lets the live tally advance between the upper-byte and lower-byte reads. A design without a coherent snapshot would return the newer low byte there. It also raises an errored cell in the same cycle as the clearing read. A design that clears before counting would report zero for that interval instead of one. The bench drives more than 65535 qualified pulses: a wrapping counter would read back a small value instead of FFFFh. It also issues strobes to unrelated addresses and repeated lower-byte reads. A design that decodes loosely would return tally bytes there or clear the tally as a side effect.

// File: rtl/tc_acc_pkg.sv
package tc_acc_pkg;

   // Decoded kind of a register read
   typedef enum logic [1:0] {
      SEL_NONE  = 2'd0,
      SEL_UPPER = 2'd1,
      SEL_LOWER = 2'd2
   } rd_sel_e;

   localparam int unsigned DEF_CNT_W  = 16;
   localparam int unsigned DEF_DATA_W = 8;
   localparam int unsigned DEF_ADDR_W = 8;

endpackage

// File: rtl/tc_evt_gate.sv
module tc_evt_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic err_cell,
   input  logic pat_lock,
   output logic evt_ok,
   output logic lock_q
);

   // Only pulses seen under pattern lock are worth counting
   assign evt_ok = err_cell & pat_lock;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lock_q <= 1'b0;
      else        lock_q <= pat_lock;
   end

endmodule

// File: rtl/tc_sat_counter.sv
module tc_sat_counter #(
   parameter int unsigned CNT_W    = 16,
   parameter bit          SATURATE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("tc_sat_counter: CNT_W must be at least 2");
      end
   endgenerate

   logic [CNT_W-1:0] bumped;

   generate
      if (SATURATE) begin : g_sat
         assign bumped = (cnt == CNT_MAX) ? CNT_MAX : cnt + CNT_ONE;
      end else begin : g_wrap
         assign bumped = cnt + CNT_ONE;
      end
   endgenerate

   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      if (clr)      cnt_d = inc ? CNT_ONE : '0;
      else if (inc) cnt_d = bumped;
      else          cnt_d = cnt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt <= '0;
      else        cnt <= cnt_d;
   end

endmodule

// File: rtl/tc_rd_port.sv
module tc_rd_port
   import tc_acc_pkg::*;
#(
   parameter int unsigned          CNT_W   = 16,
   parameter int unsigned          DATA_W  = 8,
   parameter int unsigned          ADDR_W  = 8,
   parameter logic [ADDR_W-1:0]    HI_ADDR = 'h0C,
   parameter logic [ADDR_W-1:0]    LO_ADDR = 'h0D
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   input  logic [CNT_W-1:0]  live_cnt,
   output logic              clr_live,
   output logic [DATA_W-1:0] rd_data,
   output logic [DATA_W-1:0] hold_lo
);

   generate
      if (CNT_W != 2 * DATA_W) begin : g_bad_split
         $error("tc_rd_port: CNT_W must be twice DATA_W");
      end
      if (HI_ADDR == LO_ADDR) begin : g_bad_addr
         $error("tc_rd_port: HI_ADDR and LO_ADDR must differ");
      end
   endgenerate

   rd_sel_e sel;

   always_comb begin
      sel = SEL_NONE;
      if (rd_en) begin
         if (rd_addr == HI_ADDR)      sel = SEL_UPPER;
         else if (rd_addr == LO_ADDR) sel = SEL_LOWER;
      end
   end

   assign clr_live = (sel == SEL_UPPER);

   // Snapshot of the low half, taken when the upper half is read
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_lo <= '0;
      end else begin
         case (sel)
            SEL_UPPER: hold_lo <= live_cnt[DATA_W-1:0];
            SEL_LOWER: hold_lo <= '0;
            default:   hold_lo <= hold_lo;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_data <= '0;
      end else if (rd_en) begin
         case (sel)
            SEL_UPPER: rd_data <= live_cnt[CNT_W-1:DATA_W];
            SEL_LOWER: rd_data <= hold_lo;
            default:   rd_data <= '0;
         endcase
      end
   end

endmodule

// File: rtl/tc_err_acc.sv
module tc_err_acc #(
   parameter int unsigned       CNT_W    = 16,
   parameter int unsigned       DATA_W   = 8,
   parameter int unsigned       ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] HI_ADDR  = 'h0C,
   parameter logic [ADDR_W-1:0] LO_ADDR  = 'h0D,
   parameter bit                SATURATE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              err_cell,
   input  logic              pat_lock,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic              lock_valid
);

   logic              evt_ok;
   logic              clr_live;
   logic [CNT_W-1:0]  cnt_q;
   logic [DATA_W-1:0] hold_q;

   tc_evt_gate u_gate (
      .clk      (clk),
      .rst_n    (rst_n),
      .err_cell (err_cell),
      .pat_lock (pat_lock),
      .evt_ok   (evt_ok),
      .lock_q   (lock_valid)
   );

   tc_sat_counter #(
      .CNT_W    (CNT_W),
      .SATURATE (SATURATE)
   ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (evt_ok),
      .clr   (clr_live),
      .cnt   (cnt_q)
   );

   tc_rd_port #(
      .CNT_W   (CNT_W),
      .DATA_W  (DATA_W),
      .ADDR_W  (ADDR_W),
      .HI_ADDR (HI_ADDR),
      .LO_ADDR (LO_ADDR)
   ) u_rd (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .live_cnt (cnt_q),
      .clr_live (clr_live),
      .rd_data  (rd_data),
      .hold_lo  (hold_q)
   );

endmodule

// File: rtl/tc_err_acc_chk.sv
module tc_err_acc_chk #(
   parameter int unsigned       CNT_W    = 16,
   parameter int unsigned       DATA_W   = 8,
   parameter int unsigned       ADDR_W   = 8,
   parameter logic [ADDR_W-1:0] HI_ADDR  = 'h0C,
   parameter logic [ADDR_W-1:0] LO_ADDR  = 'h0D,
   parameter bit                SATURATE = 1'b1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              err_cell,
   input logic              pat_lock,
   input logic              rd_en,
   input logic [ADDR_W-1:0] rd_addr,
   input logic [DATA_W-1:0] rd_data,
   input logic              lock_valid,
   input logic [CNT_W-1:0]  cnt,
   input logic [DATA_W-1:0] hold
);

   logic rd_hi, rd_lo, rd_other;
   assign rd_hi    = rd_en && (rd_addr == HI_ADDR);
   assign rd_lo    = rd_en && (rd_addr == LO_ADDR);
   assign rd_other = rd_en && !rd_hi && !rd_lo;

   a_r1_count_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pat_lock && err_cell && !rd_hi && cnt != {CNT_W{1'b1}})
         |=> cnt == $past(cnt) + CNT_W'(1));

   generate
      if (SATURATE) begin : g_sat_chk
         a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
            (cnt == {CNT_W{1'b1}} && !rd_hi) |=> cnt == {CNT_W{1'b1}});
      end
   endgenerate

   a_r4_unlocked_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!pat_lock && !rd_hi) |=> $stable(cnt));

   a_r5_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |=> (cnt == (($past(err_cell) && $past(pat_lock)) ? CNT_W'(1) : '0))
                && rd_data == $past(cnt[CNT_W-1:DATA_W]));

   a_r6_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
      rd_hi |=> hold == $past(cnt[DATA_W-1:0]));

   a_r7_lower_clear: assert property (@(posedge clk) disable iff (!rst_n)
      rd_lo |=> hold == '0 && rd_data == $past(hold));

   a_r8_other_addr: assert property (@(posedge clk) disable iff (!rst_n)
      rd_other |=> rd_data == '0 && $stable(hold));

   a_r9_lock_delay: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> lock_valid == $past(pat_lock));

   a_r10_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

endmodule

bind tc_err_acc tc_err_acc_chk #(
   .CNT_W    (CNT_W),
   .DATA_W   (DATA_W),
   .ADDR_W   (ADDR_W),
   .HI_ADDR  (HI_ADDR),
   .LO_ADDR  (LO_ADDR),
   .SATURATE (SATURATE)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .err_cell   (err_cell),
   .pat_lock   (pat_lock),
   .rd_en      (rd_en),
   .rd_addr    (rd_addr),
   .rd_data    (rd_data),
   .lock_valid (lock_valid),
   .cnt        (cnt_q),
   .hold       (hold_q)
);

// File: tb/tb_tc_err_acc.sv
`timescale 1ns/1ps
module tb_tc_err_acc;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       err_cell = 1'b0;
   logic       pat_lock = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_addr = 8'h00;
   logic [7:0] rd_data;
   logic       lock_valid;

   int n_checks = 0;
   int n_errors = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;   // 125 MHz

   tc_err_acc dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .err_cell   (err_cell),
      .pat_lock   (pat_lock),
      .rd_en      (rd_en),
      .rd_addr    (rd_addr),
      .rd_data    (rd_data),
      .lock_valid (lock_valid)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 200000 && !done) begin
         n_errors = n_errors + 1;
         n_checks = n_checks + 1;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks = n_checks + 1;
      if (act !== exp) begin
         n_errors = n_errors + 1;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Drive err_cell high for n cycles under the present lock value
   task automatic pulses(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) err_cell = 1'b1;
      end
      @(negedge clk) err_cell = 1'b0;
   endtask

   // One read strobe; returns the data seen one cycle later
   task automatic rd(input logic [7:0] a, input logic coincide_err, output logic [7:0] d);
      @(negedge clk);
      rd_en = 1'b1; rd_addr = a; err_cell = coincide_err;
      @(negedge clk);
      rd_en = 1'b0; rd_addr = 8'h00; err_cell = 1'b0;
      d = rd_data;
   endtask

   task automatic rd_full(output logic [15:0] v);
      logic [7:0] h, l;
      rd(8'h0C, 1'b0, h);
      rd(8'h0D, 1'b0, l);
      v = {h, l};
   endtask

   task automatic t_reset;
      logic [15:0] v;
      chk("R2 rd_data", rd_data, 0);
      chk("R2 lock_valid", lock_valid, 0);
      rd_full(v);
      chk("R2 tally", v, 0);
   endtask

   task automatic t_basic;
      logic [15:0] v;
      pat_lock = 1'b1;
      pulses(5);
      rd_full(v);
      chk("R1 five pulses", v, 5);
      rd_full(v);
      chk("R5 cleared after read", v, 0);
      pulses(300);
      rd_full(v);
      chk("R1 R5 R6 300 pulses byte split", v, 16'h012C);
   endtask

   task automatic t_unlocked;
      logic [15:0] v;
      pat_lock = 1'b0;
      pulses(10);
      rd_full(v);
      chk("R4 pulses without lock", v, 0);
      pat_lock = 1'b1;
      pulses(3);
      pat_lock = 1'b0;
      pulses(4);
      rd_full(v);
      chk("R4 mixed lock", v, 3);
   endtask

   task automatic t_lock_valid;
      @(negedge clk) pat_lock = 1'b1;
      chk("R9 not yet", lock_valid, 0);
      @(negedge clk);
      chk("R9 raised", lock_valid, 1);
      pat_lock = 1'b0;
      @(negedge clk);
      chk("R9 dropped", lock_valid, 0);
      pat_lock = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_coincide;
      logic [7:0] h, l;
      logic [15:0] v;
      pulses(2);
      rd(8'h0C, 1'b1, h);
      rd(8'h0D, 1'b0, l);
      chk("R5 old interval", {h, l}, 2);
      rd_full(v);
      chk("R5 coincident pulse kept", v, 1);
   endtask

   task automatic t_snapshot;
      logic [7:0] h, l, d;
      logic [15:0] v;
      pulses(258);
      rd(8'h0C, 1'b0, h);
      chk("R5 upper byte", h, 8'h01);
      pulses(5);
      rd(8'h0D, 1'b0, l);
      chk("R6 held lower byte", l, 8'h02);
      repeat (3) @(negedge clk);
      chk("R10 data held", rd_data, 8'h02);
      rd(8'h0D, 1'b0, d);
      chk("R7 second lower read", d, 0);
      rd_full(v);
      chk("R6 new interval", v, 5);
   endtask

   task automatic t_other;
      logic [7:0] d;
      logic [15:0] v;
      pulses(7);
      rd(8'h0C, 1'b0, d);   // snapshot: hold = 07
      rd(8'h0E, 1'b0, d);
      chk("R8 other addr data", d, 0);
      rd(8'h00, 1'b0, d);
      chk("R8 addr 00", d, 0);
      rd(8'h0D, 1'b0, d);
      chk("R8 hold untouched", d, 8'h07);
      pulses(9);
      rd(8'hFF, 1'b0, d);
      rd_full(v);
      chk("R8 tally untouched", v, 9);
   endtask

   task automatic t_saturate;
      logic [15:0] v;
      pulses(65540);
      rd_full(v);
      chk("R3 saturated", v, 16'hFFFF);
      rd_full(v);
      chk("R3 cleared after saturation", v, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_unlocked();
      t_lock_valid();
      t_coincide();
      t_snapshot();
      t_other();
      t_saturate();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule